// File: doc/BRIEF.md
# Stretchable External Memory Access Sequencer

The sequencer runs one data-memory read or write at a time on an external bus with separate address and data lines. The core raises a request with a direction bit, an address, write data and a 3-bit stretch setting. The block then steps the bus through four phases. The first is address setup, with chip-enable low and both strobes high. The second is the strobe-low phase. The third is a post-strobe phase in which write data is held or the bus is left floating. Last comes a single-clock done pulse.

The stretch setting scales the strobe width linearly. The setup phase and the post-strobe phase move in three tiers: setting 0, settings 1 to 3, and settings 4 to 7. This gives slow devices extra settle time on both sides of the strobe. The setting is sampled when the request is accepted, and the same goes for address, data and direction. Later changes on those inputs do not affect a cycle that is already running.

Top module: `xmem_stretch_seq`

## Requirements
- R1: While reset is low and after it is released with no request, bus_ce_no, bus_rd_no and bus_wr_no are 1, and bus_oe_o and done_o are 0.
- R2: The strobe (bus_rd_no for a read, bus_wr_no for a write) stays low for exactly 2 clocks at stretch 0 and for 4 × stretch clocks at stretch 1 to 7.
- R3: Chip-enable goes low with the accepted address on bus_addr_o, both strobes high, for exactly 1, 2 or 10 clocks before the strobe falls (stretch 0, 1–3, 4–7).
- R4: For a write, bus_oe_o is 1 and bus_dout_o carries the write data from the first setup clock to the end of the post-strobe phase. That phase lasts 1, 2 or 6 clocks (stretch 0, 1–3, 4–7).
- R5: For a read, bus_oe_o stays 0 for the whole cycle. After the strobe rises, chip-enable stays low with both strobes high for 1, 2 or 6 clocks (stretch 0, 1–3, 4–7).
- R6: Chip-enable stays low through setup, strobe and post-strobe phases, and rises in the clock where done_o is 1. A strobe is never low while chip-enable is high.
- R7: For a read, rdata_o holds the value of bus_din_i sampled at the clock edge that ends the last strobe-low clock. It is unchanged at all other times.
- R8: The stretch value used for a cycle is the one present on stretch_i at the accepting clock edge. Changes afterwards do not alter any phase length of that cycle.
- R9: A request is accepted only while idle. A request raised during a running cycle does not change its address or data. done_o is high for exactly one clock, after which the sequencer is idle.
- R10: Only the strobe matching the direction goes low. bus_rd_no and bus_wr_no are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, taken when idle |
| we_i | input | 1 | 1 = write, 0 = read |
| stretch_i | input | 3 | Stretch setting 0–7 |
| addr_i | input | ADDR_W | Access address |
| wdata_i | input | DATA_W | Write data |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | DATA_W | Captured read data |
| bus_addr_o | output | ADDR_W | External address bus |
| bus_ce_no | output | 1 | Chip-enable, active low |
| bus_rd_no | output | 1 | Read strobe, active low |
| bus_wr_no | output | 1 | Write strobe, active low |
| bus_dout_o | output | DATA_W | Data driven onto the bus |
| bus_oe_o | output | 1 | Data driver enable |
| bus_din_i | input | DATA_W | Data read from the bus |

## Verification
The bench runs a read and a write at every stretch value. It measures setup, strobe and post-strobe lengths at the pins, so an off-by-one at a tier boundary (stretch 3 against 4) or a linear strobe scaled wrongly shows up as a wrong count. The memory model drives known data only while the read strobe is low. A design that captures one clock late therefore returns the idle filler value. One cycle changes stretch_i right after acceptance, which exposes a design that fails to latch it as changed phase lengths. Another pulses a request with a different address mid-cycle, which exposes acceptance while busy as a wrong address or an extra cycle.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  localparam int STRETCH_W = 3;
  localparam int MAX_LEN   = 4 * ((1 << STRETCH_W) - 1);
  localparam int CNT_W     = $clog2(MAX_LEN + 1);

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_POST,
    PH_DONE
  } phase_e;
endpackage

// File: rtl/xmem_phase_len.sv
module xmem_phase_len
  import xmem_pkg::*;
(
  input  logic [STRETCH_W-1:0] stretch_i,
  output logic [CNT_W-1:0]     setup_len_o,
  output logic [CNT_W-1:0]     strobe_len_o,
  output logic [CNT_W-1:0]     post_len_o
);
  localparam int TIER_HI = 4;

  always_comb begin
    if (stretch_i == '0) begin
      setup_len_o  = CNT_W'(1);
      strobe_len_o = CNT_W'(2);
      post_len_o   = CNT_W'(1);
    end else if (int'(stretch_i) < TIER_HI) begin
      setup_len_o  = CNT_W'(2);
      strobe_len_o = CNT_W'(4 * int'(stretch_i));
      post_len_o   = CNT_W'(2);
    end else begin
      setup_len_o  = CNT_W'(10);
      strobe_len_o = CNT_W'(4 * int'(stretch_i));
      post_len_o   = CNT_W'(6);
    end
  end
endmodule

// File: rtl/xmem_seq_ctrl.sv
module xmem_seq_ctrl
  import xmem_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [STRETCH_W-1:0] stretch_i,
  output logic                 accept_o,
  output logic                 capture_o,
  output logic                 done_o,
  output logic                 ce_no,
  output logic                 rd_no,
  output logic                 wr_no,
  output logic                 oe_o
);
  phase_e               phase_q, phase_d;
  logic [CNT_W-1:0]     cnt_q;
  logic [STRETCH_W-1:0] stretch_q;
  logic                 we_q;
  logic [CNT_W-1:0]     setup_len, strobe_len, post_len;
  logic                 last;

  xmem_phase_len u_len (
    .stretch_i   (stretch_q),
    .setup_len_o (setup_len),
    .strobe_len_o(strobe_len),
    .post_len_o  (post_len)
  );

  always_comb begin
    unique case (phase_q)
      PH_SETUP:  last = (cnt_q == setup_len - CNT_W'(1));
      PH_STROBE: last = (cnt_q == strobe_len - CNT_W'(1));
      PH_POST:   last = (cnt_q == post_len - CNT_W'(1));
      default:   last = 1'b1;
    endcase
  end

  assign accept_o = (phase_q == PH_IDLE) && req_i;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:   if (req_i) phase_d = PH_SETUP;
      PH_SETUP:  if (last) phase_d = PH_STROBE;
      PH_STROBE: if (last) phase_d = PH_POST;
      PH_POST:   if (last) phase_d = PH_DONE;
      PH_DONE:   phase_d = PH_IDLE;
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      stretch_q <= '0;
      we_q      <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= (phase_d != phase_q) ? '0 : cnt_q + CNT_W'(1);
      if (accept_o) begin
        stretch_q <= stretch_i;
        we_q      <= we_i;
      end
    end
  end

  logic active;
  assign active    = (phase_q == PH_SETUP) || (phase_q == PH_STROBE) || (phase_q == PH_POST);
  assign ce_no     = !active;
  assign rd_no     = !((phase_q == PH_STROBE) && !we_q);
  assign wr_no     = !((phase_q == PH_STROBE) && we_q);
  assign oe_o      = active && we_q;
  assign done_o    = (phase_q == PH_DONE);
  assign capture_o = (phase_q == PH_STROBE) && last && !we_q;

  // R10
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no && !wr_no));
  // R6
  strobe_under_ce_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_no || !wr_no) |-> !ce_no);
  // R4
  write_driven_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_no |-> oe_o);
  // R5
  read_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> !oe_o);
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && ce_no));
  // R8
  stretch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_no && !accept_o) |=> $stable(stretch_q));
endmodule

// File: rtl/xmem_data_path.sv
module xmem_data_path #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] bus_din_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      wdata_o <= '0;
      rdata_o <= '0;
    end else begin
      if (accept_i) begin
        addr_o  <= addr_i;
        wdata_o <= wdata_i;
      end
      if (capture_i) rdata_o <= bus_din_i;
    end
  end

  // R7
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> $stable(rdata_o));
endmodule

// File: rtl/xmem_stretch_seq.sv
module xmem_stretch_seq
  import xmem_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [STRETCH_W-1:0] stretch_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic                 done_o,
  output logic [DATA_W-1:0]    rdata_o,
  output logic [ADDR_W-1:0]    bus_addr_o,
  output logic                 bus_ce_no,
  output logic                 bus_rd_no,
  output logic                 bus_wr_no,
  output logic [DATA_W-1:0]    bus_dout_o,
  output logic                 bus_oe_o,
  input  logic [DATA_W-1:0]    bus_din_i
);
  logic accept, capture;

  xmem_seq_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .we_i     (we_i),
    .stretch_i(stretch_i),
    .accept_o (accept),
    .capture_o(capture),
    .done_o   (done_o),
    .ce_no    (bus_ce_no),
    .rd_no    (bus_rd_no),
    .wr_no    (bus_wr_no),
    .oe_o     (bus_oe_o)
  );

  xmem_data_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .capture_i(capture),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .bus_din_i(bus_din_i),
    .addr_o   (bus_addr_o),
    .wdata_o  (bus_dout_o),
    .rdata_o  (rdata_o)
  );
endmodule

// File: tb/xmem_stretch_seq_tb_top.sv
module xmem_stretch_seq_tb_top;
  localparam int AW = 16;
  localparam int DW = 8;

  typedef struct {
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    int            s;
  } item_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 1'b0, we_i = 1'b0;
  logic [2:0] stretch_i = '0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic done_o, bus_ce_no, bus_rd_no, bus_wr_no, bus_oe_o;
  logic [DW-1:0] rdata_o, bus_dout_o, bus_din_i;
  logic [AW-1:0] bus_addr_o;

  int checks = 0, errors = 0;
  item_t exp_q[$];

  always #10 clk_i = ~clk_i;

  assign bus_din_i = !bus_rd_no ? (bus_addr_o[DW-1:0] ^ 8'h5A) : 8'hEE;

  xmem_stretch_seq #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .stretch_i(stretch_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .done_o(done_o), .rdata_o(rdata_o), .bus_addr_o(bus_addr_o),
    .bus_ce_no(bus_ce_no), .bus_rd_no(bus_rd_no), .bus_wr_no(bus_wr_no),
    .bus_dout_o(bus_dout_o), .bus_oe_o(bus_oe_o), .bus_din_i(bus_din_i)
  );

  function automatic int setup_of(int s); return s == 0 ? 1 : (s < 4 ? 2 : 10); endfunction
  function automatic int width_of(int s); return s == 0 ? 2 : 4 * s; endfunction
  function automatic int post_of(int s);  return s == 0 ? 1 : (s < 4 ? 2 : 6); endfunction

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  // driver: mode 1 = change stretch after accept, mode 2 = request while busy
  task automatic run(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input int s, input int mode);
    item_t it;
    it.we = we; it.addr = a; it.data = d; it.s = s;
    exp_q.push_back(it);
    @(negedge clk_i);
    req_i = 1'b1; we_i = we; addr_i = a; wdata_i = d; stretch_i = 3'(s);
    @(negedge clk_i);
    req_i = 1'b0;
    if (mode == 1) stretch_i = ~3'(s);
    if (mode == 2) begin
      req_i = 1'b1; addr_i = 16'hFFFF; wdata_i = 8'h00; we_i = ~we;
      @(negedge clk_i);
      req_i = 1'b0;
    end
    while (!done_o) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni && !bus_ce_no) begin
        item_t it;
        int n;
        if (exp_q.size() == 0) begin
          chk(0, "R9 unexpected cycle", 1, 0);
          continue;
        end
        it = exp_q.pop_front();
        n = 0;
        while (!bus_ce_no && bus_rd_no && bus_wr_no) begin
          n++;
          chk(bus_addr_o == it.addr, "R3 addr", int'(bus_addr_o), int'(it.addr));
          chk(bus_oe_o == it.we, "R4/R5 oe in setup", int'(bus_oe_o), int'(it.we));
          @(negedge clk_i);
        end
        chk(n == setup_of(it.s), "R3 setup len", n, setup_of(it.s));
        chk((it.we ? !bus_wr_no && bus_rd_no : !bus_rd_no && bus_wr_no),
            "R10 strobe kind", int'({bus_rd_no, bus_wr_no}), it.we ? 2 : 1);
        n = 0;
        while (!bus_rd_no || !bus_wr_no) begin
          n++;
          chk(!bus_ce_no, "R6 ce in strobe", int'(bus_ce_no), 0);
          if (it.we) chk(bus_oe_o && bus_dout_o == it.data, "R4 data in strobe",
                         int'(bus_dout_o), int'(it.data));
          @(negedge clk_i);
        end
        chk(n == width_of(it.s), "R2 strobe len", n, width_of(it.s));
        n = 0;
        while (!bus_ce_no && bus_rd_no && bus_wr_no) begin
          n++;
          chk(bus_oe_o == it.we, "R4/R5 oe post", int'(bus_oe_o), int'(it.we));
          @(negedge clk_i);
        end
        chk(n == post_of(it.s), it.we ? "R4 hold len" : "R5 float len", n, post_of(it.s));
        chk(done_o && bus_ce_no, "R6 ce release with done", int'(done_o), 1);
        if (!it.we)
          chk(rdata_o == (it.addr[DW-1:0] ^ 8'h5A), "R7 read data",
              int'(rdata_o), int'(it.addr[DW-1:0] ^ 8'h5A));
        @(negedge clk_i);
        chk(!done_o && bus_ce_no, "R9 done single pulse", int'(done_o), 0);
      end
    end
  end

  initial begin
    fork
      begin
        #5;
        chk(bus_ce_no && bus_rd_no && bus_wr_no && !bus_oe_o && !done_o,
            "R1 in reset", int'({bus_ce_no, bus_rd_no, bus_wr_no}), 7);
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        repeat (3) @(negedge clk_i);
        chk(bus_ce_no && bus_rd_no && bus_wr_no && !bus_oe_o && !done_o,
            "R1 idle", int'({bus_ce_no, bus_rd_no, bus_wr_no}), 7);
        for (int s = 0; s < 8; s++) begin
          run(1'b0, 16'h1200 + 16'(s * 17), 8'h00, s, 0);
          run(1'b1, 16'h3400 + 16'(s), 8'hA0 + 8'(s), s, 0);
        end
        run(1'b0, 16'h00C3, 8'h00, 3, 1);   // R8 read, stretch changed to 4
        run(1'b1, 16'h0077, 8'h3C, 4, 1);   // R8 write, stretch changed to 3
        run(1'b0, 16'h0A5A, 8'h00, 2, 2);   // R9 request while busy
        run(1'b1, 16'h0B0B, 8'h99, 7, 2);   // R9 request while busy
        repeat (4) @(negedge clk_i);
        chk(exp_q.size() == 0, "R9 all cycles seen", exp_q.size(), 0);
        chk(bus_ce_no && !done_o, "R9 idle at end", int'(bus_ce_no), 1);
      end
      begin
        repeat (20000) @(posedge clk_i);
        chk(0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule